// File: doc/BRIEF.md
# Status-Decoded Bus Command Generator

This block sits beside a processor that does not drive its own bus strobes. The processor presents a 3-bit status code announcing the type of the next bus cycle. The block watches that code and produces the whole cycle on its own. It pulses the address-latch strobe, steers the data transceivers with an enable and a direction line, and issues one active-low command strobe for the kind of transfer. The code 111 means the bus is quiet. A cycle starts on the first clock in which the code has moved away from 111.

The block keeps its own bus phase: T1, T2, T3, optional wait states, then T4. It samples a ready input at the end of T3 and at the end of each wait state. A slow memory or port can stretch the cycle this way. Read-type commands cover T2 through T4. A write has two strobes: an early one that covers T2 through T4, and a normal one that covers T3 through T4. An interrupt acknowledge produces one strobe per status cycle. The processor runs two such cycles back to back to make the usual two-pulse acknowledge sequence.

Top module: `bus_cmd_gen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block returns to idle. After that edge `ale`, `den` and `dir_tx` are 0 and every command output is 1.
- R2: A cycle starts when `bus_stat` differs from 111 and was 111 at the previous rising edge, while the block is idle or in T4. `ale` is then 1 for exactly the next clock (T1), followed by T2 and T3.
- R3: Code 101 (memory read) and code 100 (code fetch) drive `mem_rd_n` low during T2, T3, every wait state and T4. Code 001 (I/O read) does the same on `io_rd_n`.
- R4: Code 110 (memory write) drives `mem_wr_adv_n` low from T2 through T4 and `mem_wr_n` low from T3 through T4. Code 010 (I/O write) does the same on `io_wr_adv_n` and `io_wr_n`.
- R5: `dir_tx` is 1 from T1 through T4 of a write cycle (codes 110, 010). It is 0 at all other times.
- R6: `den` is 1 from T2 through T4 of every cycle except halt. Code 011 (halt) produces the T1 `ale` pulse but no `den` and no command strobe.
- R7: If `rdy` is low at the rising edge that ends T3 or a wait state, another wait state follows. All outputs hold their T3 values during wait states. T4 follows the first edge with `rdy` high.
- R8: Code 000 (interrupt acknowledge) drives `irq_ack_n` low from T2 through T4. Two acknowledge cycles issued back to back give two separate low pulses, because the strobe is high during the second T1.
- R9: Every command output is 1 in the clock after T4, whether the block goes idle or starts a new cycle.
- R10: A code that stays non-passive after T4, and a status change during T2, T3 or a wait state, starts no cycle.
- R11: At most one of the memory-read, memory-write, I/O-read, I/O-write and acknowledge strobes is low at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_stat | input | 3 | Status code from the processor, 111 = passive |
| rdy | input | 1 | Transfer ready, high ends the cycle after T3 or a wait state |
| ale | output | 1 | Address latch strobe, high in T1 |
| den | output | 1 | Transceiver enable, high T2..T4 |
| dir_tx | output | 1 | Transceiver direction, 1 = processor drives data |
| mem_rd_n | output | 1 | Memory read command |
| mem_wr_n | output | 1 | Memory write command, T3..T4 |
| mem_wr_adv_n | output | 1 | Early memory write command, T2..T4 |
| io_rd_n | output | 1 | I/O read command |
| io_wr_n | output | 1 | I/O write command, T3..T4 |
| io_wr_adv_n | output | 1 | Early I/O write command, T2..T4 |
| irq_ack_n | output | 1 | Interrupt acknowledge strobe |

## Verification
Two situations are hard to reach. The first is a new cycle starting straight out of T4 with no idle clock between. That needs the status back at 111 during T3 and the next code presented in the T4 clock itself. The second is a status change that lands inside T2..T3 and must be ignored. The stimulus task returns the status to passive after T2 and can optionally present a code during T3 or keep the code non-passive. A caller then issues the next cycle in the same clock as the T4 check. This exercises the back-to-back acknowledge pair and the rejected-edge cases without an idle gap.

// File: rtl/bcg_pkg.sv
// Package: shared codes, phase type and the command table of the bus
// command generator. Assumes a 3-bit status code.
package bcg_pkg;

    localparam int STAT_W = 3;
    typedef logic [STAT_W-1:0] stat_t;

    localparam stat_t ST_INTA  = 3'b000;
    localparam stat_t ST_IORD  = 3'b001;
    localparam stat_t ST_IOWR  = 3'b010;
    localparam stat_t ST_HALT  = 3'b011;
    localparam stat_t ST_FETCH = 3'b100;
    localparam stat_t ST_MEMRD = 3'b101;
    localparam stat_t ST_MEMWR = 3'b110;
    localparam stat_t ST_IDLE  = 3'b111;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_T1   = 3'd1,
        PH_T2   = 3'd2,
        PH_T3   = 3'd3,
        PH_TW   = 3'd4,
        PH_T4   = 3'd5
    } phase_t;

    // Command strobe indices
    localparam int CMD_MRD   = 0;
    localparam int CMD_MWR   = 1;
    localparam int CMD_AMWR  = 2;
    localparam int CMD_IORD  = 3;
    localparam int CMD_IOWR  = 4;
    localparam int CMD_AIOWR = 5;
    localparam int CMD_INTA  = 6;
    localparam int NCMD      = 7;

    // True when the status code selects strobe idx
    function automatic logic cmd_hit(input int idx, input stat_t c);
        case (idx)
            CMD_MRD:   return (c == ST_MEMRD) || (c == ST_FETCH);
            CMD_MWR,
            CMD_AMWR:  return (c == ST_MEMWR);
            CMD_IORD:  return (c == ST_IORD);
            CMD_IOWR,
            CMD_AIOWR: return (c == ST_IOWR);
            CMD_INTA:  return (c == ST_INTA);
            default:   return 1'b0;
        endcase
    endfunction

    // True when strobe idx starts in T3 instead of T2
    function automatic logic cmd_late(input int idx);
        return (idx == CMD_MWR) || (idx == CMD_IOWR);
    endfunction

    function automatic logic is_write(input stat_t c);
        return (c == ST_MEMWR) || (c == ST_IOWR);
    endfunction

endpackage

// File: rtl/bcg_start_detect.sv
// Start detector: remembers the previous status sample and flags the
// clock in which the code leaves the passive value while the bus is free
// (idle or in T4). Captures the code of the cycle being started.
// Assumes the status input is already synchronous to clk.
module bcg_start_detect
    import bcg_pkg::*;
#(
    parameter stat_t PASSIVE = ST_IDLE
) (
    input  logic   clk,
    input  logic   rst_n,
    input  stat_t  stat_i,
    input  phase_t phase_i,
    output logic   start_o,
    output stat_t  code_o
);

    stat_t stat_prev;
    logic  bus_free;

    // Bus may take a new cycle only when idle or finishing T4
    always_comb bus_free = (phase_i == PH_IDLE) || (phase_i == PH_T4);

    // Start on a passive-to-active transition of the status code
    always_comb start_o = bus_free && (stat_i != PASSIVE) && (stat_prev == PASSIVE);

    // Status history register
    always_ff @(posedge clk) begin
        if (!rst_n) stat_prev <= PASSIVE;
        else        stat_prev <= stat_i;
    end

    // Capture the code of a starting cycle
    always_ff @(posedge clk) begin
        if (!rst_n)       code_o <= PASSIVE;
        else if (start_o) code_o <= stat_i;
    end

    // R10: the cycle code is frozen once the cycle has left T1
    a_r10_code_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i inside {PH_T2, PH_T3, PH_TW}) |=> $stable(code_o));

    // R10: no start without a passive sample one edge earlier
    a_r10_start_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o && $past(rst_n)) |-> ($past(stat_i) == PASSIVE));

endmodule

// File: rtl/bcg_phase_fsm.sv
// Phase sequencer: steps T1, T2, T3, inserts wait states while ready is
// low at the end of T3 or a wait state, then T4, then idle or a new T1.
// Assumes start_i is only raised when idle or in T4.
module bcg_phase_fsm
    import bcg_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start_i,
    input  logic   rdy_i,
    output phase_t phase_o
);

    phase_t phase_nx;

    // Next-phase selection
    always_comb begin
        phase_nx = PH_IDLE;
        case (phase_o)
            PH_IDLE: phase_nx = start_i ? PH_T1 : PH_IDLE;
            PH_T1:   phase_nx = PH_T2;
            PH_T2:   phase_nx = PH_T3;
            PH_T3:   phase_nx = rdy_i ? PH_T4 : PH_TW;
            PH_TW:   phase_nx = rdy_i ? PH_T4 : PH_TW;
            PH_T4:   phase_nx = start_i ? PH_T1 : PH_IDLE;
            default: phase_nx = PH_IDLE;
        endcase
    end

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n) phase_o <= PH_IDLE;
        else        phase_o <= phase_nx;
    end

    // R2: a detected start is followed by T1
    a_r2_start_to_t1: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (phase_o == PH_T1));

    // R7: a wait state only follows a low ready sample
    a_r7_wait_on_low_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o inside {PH_T3, PH_TW}) && !rdy_i |=> (phase_o == PH_TW));

    // R2: T1 is always followed by T2
    a_r2_t1_to_t2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_T1) |=> (phase_o == PH_T2));

endmodule

// File: rtl/bcg_cmd_decode.sv
// Output decoder: turns the current phase and cycle code into the latch
// strobe, transceiver enable and direction, and one active-low strobe per
// command kind. Strobe windows come from the package command table.
// Assumes code_i holds the code of the current cycle from T1 to T4.
module bcg_cmd_decode
    import bcg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  phase_t          phase_i,
    input  stat_t           code_i,
    output logic            ale_o,
    output logic            den_o,
    output logic            dir_tx_o,
    output logic [NCMD-1:0] cmd_n_o
);

    logic in_cycle;
    logic data_win;
    logic late_win;

    // Phase windows shared by all strobes
    always_comb begin
        in_cycle = (phase_i != PH_IDLE);
        data_win = phase_i inside {PH_T2, PH_T3, PH_TW, PH_T4};
        late_win = phase_i inside {PH_T3, PH_TW, PH_T4};
    end

    // Control outputs
    always_comb begin
        ale_o    = (phase_i == PH_T1);
        den_o    = data_win && (code_i != ST_HALT);
        dir_tx_o = in_cycle && is_write(code_i);
    end

    // One strobe per command kind, window picked by the table
    for (genvar gi = 0; gi < NCMD; gi++) begin : g_cmd
        logic win;
        always_comb win = cmd_late(gi) ? late_win : data_win;
        assign cmd_n_o[gi] = ~(cmd_hit(gi, code_i) & win);
    end

    // R2: the latch strobe lasts one clock
    a_r2_ale_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ale_o |=> !ale_o);

    // R4: a normal write strobe is always covered by its early strobe
    a_r4_mwr_under_adv: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_n_o[CMD_MWR] |-> !cmd_n_o[CMD_AMWR]);
    a_r4_iowr_under_adv: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_n_o[CMD_IOWR] |-> !cmd_n_o[CMD_AIOWR]);

    // R6: a halt cycle issues no command and no data enable
    a_r6_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (code_i == ST_HALT) |-> (&cmd_n_o && !den_o));

    // R7: outputs hold during wait states
    a_r7_hold_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i == PH_TW) |-> $stable({cmd_n_o, den_o, dir_tx_o}));

    // R9: all strobes released in the clock after T4
    a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i == PH_T4) |=> &cmd_n_o);

    // R11: never two command kinds at once
    a_r11_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~{cmd_n_o[CMD_MRD], cmd_n_o[CMD_MWR], cmd_n_o[CMD_IORD],
                     cmd_n_o[CMD_IOWR], cmd_n_o[CMD_INTA]}) <= 1);

endmodule

// File: rtl/bus_cmd_gen.sv
// Top: status-decoded bus command generator. Detects the start of a bus
// cycle from the status code, sequences the bus phases with ready-driven
// wait states and decodes the control and command outputs.
// Assumes bus_stat and rdy are synchronous to clk.
module bus_cmd_gen
    import bcg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] bus_stat,
    input  logic       rdy,
    output logic       ale,
    output logic       den,
    output logic       dir_tx,
    output logic       mem_rd_n,
    output logic       mem_wr_n,
    output logic       mem_wr_adv_n,
    output logic       io_rd_n,
    output logic       io_wr_n,
    output logic       io_wr_adv_n,
    output logic       irq_ack_n
);

    phase_t          phase;
    stat_t           code;
    logic            start;
    logic [NCMD-1:0] cmd_n;

    bcg_start_detect #(.PASSIVE(ST_IDLE)) u_start (
        .clk     (clk),
        .rst_n   (rst_n),
        .stat_i  (bus_stat),
        .phase_i (phase),
        .start_o (start),
        .code_o  (code)
    );

    bcg_phase_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .rdy_i   (rdy),
        .phase_o (phase)
    );

    bcg_cmd_decode u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase_i  (phase),
        .code_i   (code),
        .ale_o    (ale),
        .den_o    (den),
        .dir_tx_o (dir_tx),
        .cmd_n_o  (cmd_n)
    );

    // Map the strobe vector onto named ports
    always_comb begin
        mem_rd_n     = cmd_n[CMD_MRD];
        mem_wr_n     = cmd_n[CMD_MWR];
        mem_wr_adv_n = cmd_n[CMD_AMWR];
        io_rd_n      = cmd_n[CMD_IORD];
        io_wr_n      = cmd_n[CMD_IOWR];
        io_wr_adv_n  = cmd_n[CMD_AIOWR];
        irq_ack_n    = cmd_n[CMD_INTA];
    end

endmodule

// File: tb/bus_cmd_gen_tb.sv
module bus_cmd_gen_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_stat = 3'b111;
    logic       rdy = 1'b1;
    logic       ale, den, dir_tx, mem_rd_n, mem_wr_n, mem_wr_adv_n;
    logic       io_rd_n, io_wr_n, io_wr_adv_n, irq_ack_n;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bus_cmd_gen u_dut (
        .clk(clk), .rst_n(rst_n), .bus_stat(bus_stat), .rdy(rdy),
        .ale(ale), .den(den), .dir_tx(dir_tx),
        .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .mem_wr_adv_n(mem_wr_adv_n),
        .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .io_wr_adv_n(io_wr_adv_n),
        .irq_ack_n(irq_ack_n)
    );

    // Phase numbers used by the bench: 0 idle,1 T1,2 T2,3 T3,4 wait,5 T4
    localparam int P_IDLE = 0, P_T1 = 1, P_T2 = 2, P_T3 = 3, P_TW = 4, P_T4 = 5;

    // Expected {ale,den,dir_tx,mrd,mwr,amwr,iord,iowr,aiowr,inta}
    function automatic logic [9:0] exp_out(input logic [2:0] c, input int ph);
        logic data, late, wr;
        data = (ph >= P_T2);
        late = (ph >= P_T3);
        wr   = (c == 3'b110) || (c == 3'b010);
        exp_out[9] = (ph == P_T1);                                  // R2
        exp_out[8] = data && (c != 3'b011);                         // R6
        exp_out[7] = wr && (ph != P_IDLE);                          // R5
        exp_out[6] = !(data && (c == 3'b101 || c == 3'b100));       // R3
        exp_out[5] = !(late && c == 3'b110);                        // R4
        exp_out[4] = !(data && c == 3'b110);                        // R4
        exp_out[3] = !(data && c == 3'b001);                        // R3
        exp_out[2] = !(late && c == 3'b010);                        // R4
        exp_out[1] = !(data && c == 3'b010);                        // R4
        exp_out[0] = !(data && c == 3'b000);                        // R8
    endfunction

    task automatic check(input string tag, input logic [9:0] exp);
        logic [9:0] act;
        act = {ale, den, dir_tx, mem_rd_n, mem_wr_n, mem_wr_adv_n,
               io_rd_n, io_wr_n, io_wr_adv_n, irq_ack_n};
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string tag_for(input logic [2:0] c);
        case (c)
            3'b101, 3'b100, 3'b001: return "R3";
            3'b110, 3'b010:         return "R4/R5";
            3'b011:                 return "R6";
            3'b000:                 return "R8";
            default:                return "R2";
        endcase
    endfunction

    // Runs one bus cycle; called just after a falling edge, returns just
    // after the T4 check. keep: status stays non-passive; glitch: a code
    // is presented during T3.
    task automatic run_cycle(input logic [2:0] c, input int waits,
                             input bit keep, input bit glitch);
        bus_stat = c;
        @(negedge clk); check("R2 T1", exp_out(c, P_T1));
        @(negedge clk); check({tag_for(c), " T2"}, exp_out(c, P_T2));
        if (!keep) bus_stat = 3'b111;
        rdy = (waits == 0);
        @(negedge clk); check({tag_for(c), " T3"}, exp_out(c, P_T3));
        if (glitch) bus_stat = 3'b110;
        for (int k = 0; k < waits; k++) begin
            @(negedge clk); check("R7 wait", exp_out(c, P_TW));
            if (k == waits - 1) rdy = 1'b1;
        end
        @(negedge clk); check({tag_for(c), " T4"}, exp_out(c, P_T4));
        rdy = 1'b1;
    endtask

    // Stimulus table: {code, wait count}
    localparam int NVEC = 10;
    localparam logic [4:0] VEC [NVEC] = '{
        {3'b101, 2'd0}, {3'b100, 2'd1}, {3'b001, 2'd0}, {3'b110, 2'd0},
        {3'b010, 2'd2}, {3'b011, 2'd0}, {3'b000, 2'd0}, {3'b110, 2'd3},
        {3'b001, 2'd1}, {3'b101, 2'd2}
    };

    // Watchdog
    initial begin
        #(4 * 20000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", 10'b000_1111111);
        rst_n = 1'b1;
        @(negedge clk); check("R1 idle", exp_out(3'b111, P_IDLE));

        // Table walk, each cycle followed by an idle check (R9)
        for (int i = 0; i < NVEC; i++) begin
            run_cycle(VEC[i][4:2], int'(VEC[i][1:0]), 1'b0, 1'b0);
            @(negedge clk); check("R9 after T4", exp_out(3'b111, P_IDLE));
        end

        // R8: two acknowledge cycles back to back, separated in T1
        run_cycle(3'b000, 0, 1'b0, 1'b0);
        run_cycle(3'b000, 0, 1'b0, 1'b0);
        @(negedge clk); check("R8 after pair", exp_out(3'b111, P_IDLE));

        // R9: write straight into read without idle clock
        run_cycle(3'b110, 1, 1'b0, 1'b0);
        run_cycle(3'b101, 0, 1'b0, 1'b0);
        @(negedge clk); check("R9 chain end", exp_out(3'b111, P_IDLE));

        // R10: status held non-passive after T4 starts nothing
        run_cycle(3'b101, 0, 1'b1, 1'b0);
        @(negedge clk); check("R10 held code", exp_out(3'b111, P_IDLE));
        @(negedge clk); check("R10 held code", exp_out(3'b111, P_IDLE));
        bus_stat = 3'b111;
        @(negedge clk); check("R10 released", exp_out(3'b111, P_IDLE));

        // R10: a code appearing during T3 is ignored
        run_cycle(3'b001, 0, 1'b0, 1'b1);
        @(negedge clk); check("R10 T3 change", exp_out(3'b111, P_IDLE));
        @(negedge clk); check("R10 T3 change", exp_out(3'b111, P_IDLE));
        bus_stat = 3'b111;
        @(negedge clk);

        // R1: reset in the middle of a write cycle
        bus_stat = 3'b110;
        @(negedge clk); check("R2 T1", exp_out(3'b110, P_T1));
        @(negedge clk); check("R4 T2", exp_out(3'b110, P_T2));
        rst_n = 1'b0; bus_stat = 3'b111;
        @(negedge clk); check("R1 mid-cycle reset", 10'b000_1111111);
        rst_n = 1'b1;
        @(negedge clk); check("R1 after reset", exp_out(3'b111, P_IDLE));

        // Cycle after reset still works
        run_cycle(3'b010, 0, 1'b0, 1'b0);
        @(negedge clk); check("R9 final", exp_out(3'b111, P_IDLE));

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end

endmodule